// File: doc/BRIEF.md
# Prefix-Extended Stack Pointer Subtractor

This block executes a single kind of instruction from a 16-bit instruction stream: a subtraction whose result lands in a 24-bit stack pointer. It also tracks immediate-extension prefix words that come before that instruction. Because of this, one opcode works in three ways:

- Stack pointer minus a general register.
- A general register minus a zero-extended 13-bit immediate.
- A general register minus a 24-bit immediate built from two prefixes.

The surrounding pipeline presents one word per cycle with a valid qualifier. It also raises a flag when the word sits in the delay slot of a delayed branch. The block addresses one of eight 24-bit general registers through a combinational read port and updates its own stack pointer at the clock edge of the cycle the instruction is presented. Other opcodes only consume and clear pending prefix state. The block writes no general register and leaves the flags alone.

Top module: `spSubUnit`

## Requirements
- R1: After reset the stack pointer reads 0 and no prefix is pending.
- R2: A word with bits 15:3 equal to 0011000000011 and instrValid high is the subtract instruction. Bits 2:0 select rs, and rdAddr carries them. spWriteEn is high in that cycle, and spValue holds the new value from the next rising edge.
- R3: With no pending prefix, the new stack pointer is the old stack pointer minus rs, modulo 2^24.
- R4: A prefix word has bits 15:13 equal to 110 and carries a 13-bit value in bits 12:0. With exactly one pending prefix, the new stack pointer is rs minus that value zero-extended to 24 bits, and the old stack pointer is not an operand.
- R5: With two pending prefixes, the immediate is {older[10:0], newer[12:0]}: the earlier prefix gives bits 23:13 and the later one gives bits 12:0. The new stack pointer is rs minus that immediate.
- R6: A third consecutive prefix discards the oldest, so only the last two prefixes form the immediate.
- R7: When inDelaySlot is high, a subtract ignores any pending prefixes and computes old stack pointer minus rs.
- R8: Bits 1:0 of the stack pointer are always written as 0.
- R9: Any valid non-prefix word, including the subtract itself and any other opcode, empties the prefix state.
- R10: Non-subtract words leave the stack pointer unchanged, and so do cycles with instrValid low. A cycle with instrValid low also leaves the prefix state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | instrWord holds an instruction this cycle |
| instrWord | input | 16 | Instruction word |
| inDelaySlot | input | 1 | Word sits in a delayed-branch slot |
| rdAddr | output | 3 | General register read address (rs) |
| rdData | input | 24 | General register read data |
| spValue | output | 24 | Current stack pointer |
| spWriteEn | output | 1 | Stack pointer is written at this edge |

## Verification
A wrong prefix count or a wrong prefix slot stays hidden until the next subtract. At that point it shows at once on spValue, one edge after the instruction, as a difference equal to the misused immediate or as the old stack pointer showing up as an operand. For that reason the stimulus mixes runs of zero to four prefixes, idle cycles between prefixes, foreign opcodes and delay-slot subtracts. Each spValue is then compared after every edge, so a stale immediate is caught on the first subtract it corrupts.

// File: rtl/spSubPkg.sv
package spSubPkg;
  localparam int SP_W     = 24;
  localparam int IMM_LO_W = 13;
  localparam int IMM_HI_W = SP_W - IMM_LO_W;
  localparam int REG_AW   = 3;
  localparam int ZERO_LSB = 2;

  localparam logic [12:0] SUB_PATTERN = 13'b0011000000011;
  localparam logic [2:0]  PREFIX_TAG  = 3'b110;

  typedef enum logic [1:0] {
    MODE_REG   = 2'd0,
    MODE_IMM13 = 2'd1,
    MODE_IMM24 = 2'd2
  } opMode_e;

  typedef struct packed {
    logic    writeSp;
    logic    pushPrefix;
    logic    clearPrefix;
    opMode_e mode;
  } ctrlStrobes_t;
endpackage

// File: rtl/spSubCtrl.sv
module spSubCtrl
  import spSubPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrValid,
  input  logic [15:0]  instrWord,
  input  logic         inDelaySlot,
  output ctrlStrobes_t strobes
);
  logic [1:0] prefixCount;
  logic isSub;
  logic isPrefix;

  assign isSub    = instrValid && (instrWord[15:3] == SUB_PATTERN);
  assign isPrefix = instrValid && (instrWord[15:13] == PREFIX_TAG);

  always_comb begin
    strobes.writeSp     = isSub;
    strobes.pushPrefix  = isPrefix;
    strobes.clearPrefix = instrValid && !isPrefix;
    if (inDelaySlot || prefixCount == 2'd0) strobes.mode = MODE_REG;
    else if (prefixCount == 2'd1)           strobes.mode = MODE_IMM13;
    else                                    strobes.mode = MODE_IMM24;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefixCount <= 2'd0;
    end else if (strobes.pushPrefix) begin
      if (prefixCount != 2'd2) prefixCount <= prefixCount + 2'd1;
    end else if (strobes.clearPrefix) begin
      prefixCount <= 2'd0;
    end
  end
endmodule

// File: rtl/spSubDatapath.sv
module spSubDatapath
  import spSubPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [IMM_LO_W-1:0] prefixBits,
  input  logic [SP_W-1:0]     rdData,
  output logic [SP_W-1:0]     spValue
);
  logic [IMM_LO_W-1:0] olderImm;
  logic [IMM_LO_W-1:0] newerImm;
  logic [SP_W-1:0]     minuend;
  logic [SP_W-1:0]     subtrahend;
  logic [SP_W-1:0]     difference;
  logic [SP_W-1:0]     spNext;

  always_comb begin
    case (strobes.mode)
      MODE_IMM13: begin
        minuend    = rdData;
        subtrahend = {{(SP_W-IMM_LO_W){1'b0}}, newerImm};
      end
      MODE_IMM24: begin
        minuend    = rdData;
        subtrahend = {olderImm[IMM_HI_W-1:0], newerImm};
      end
      default: begin
        minuend    = spValue;
        subtrahend = rdData;
      end
    endcase
    difference = minuend - subtrahend;
    spNext     = {difference[SP_W-1:ZERO_LSB], {ZERO_LSB{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      olderImm <= '0;
      newerImm <= '0;
      spValue  <= '0;
    end else begin
      if (strobes.pushPrefix) begin
        olderImm <= newerImm;
        newerImm <= prefixBits;
      end
      if (strobes.writeSp) spValue <= spNext;
    end
  end
endmodule

// File: rtl/spSubUnit.sv
module spSubUnit
  import spSubPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic              inDelaySlot,
  output logic [REG_AW-1:0] rdAddr,
  input  logic [SP_W-1:0]   rdData,
  output logic [SP_W-1:0]   spValue,
  output logic              spWriteEn
);
  ctrlStrobes_t strobes;

  assign rdAddr    = instrWord[REG_AW-1:0];
  assign spWriteEn = strobes.writeSp;

  spSubCtrl uCtrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .instrWord(instrWord), .inDelaySlot(inDelaySlot), .strobes(strobes)
  );

  spSubDatapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .prefixBits(instrWord[IMM_LO_W-1:0]), .rdData(rdData), .spValue(spValue)
  );
endmodule

// File: rtl/spSubChecker.sv
module spSubChecker
  import spSubPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [15:0]       instrWord,
  input logic              inDelaySlot,
  input logic [REG_AW-1:0] rdAddr,
  input logic [SP_W-1:0]   rdData,
  input logic [SP_W-1:0]   spValue,
  input logic              spWriteEn
);
  localparam logic [SP_W-1:0] KEEP_MASK = {{(SP_W-ZERO_LSB){1'b1}}, {ZERO_LSB{1'b0}}};
  logic [1:0]          seenCount;
  logic [IMM_LO_W-1:0] seenOld;
  logic [IMM_LO_W-1:0] seenNew;
  logic                wordIsPrefix;
  logic                wordIsSub;

  assign wordIsPrefix = instrValid && (instrWord[15:13] == PREFIX_TAG);
  assign wordIsSub    = instrValid && (instrWord[15:3] == SUB_PATTERN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenCount <= 2'd0;
      seenOld   <= '0;
      seenNew   <= '0;
    end else if (wordIsPrefix) begin
      seenCount <= (seenCount == 2'd2) ? 2'd2 : seenCount + 2'd1;
      seenOld   <= seenNew;
      seenNew   <= instrWord[IMM_LO_W-1:0];
    end else if (instrValid) begin
      seenCount <= 2'd0;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> spValue == '0); // R1
  AST_WRITE_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    spWriteEn == wordIsSub); // R2
  AST_REG_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (wordIsSub && (seenCount == 2'd0 || inDelaySlot)) |=>
      spValue == (($past(spValue) - $past(rdData)) & KEEP_MASK)); // R3 R7
  AST_IMM13_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (wordIsSub && !inDelaySlot && seenCount == 2'd1) |=>
      spValue == (($past(rdData) - {{(SP_W-IMM_LO_W){1'b0}}, $past(seenNew)}) & KEEP_MASK)); // R4
  AST_IMM24_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (wordIsSub && !inDelaySlot && seenCount == 2'd2) |=>
      spValue == (($past(rdData) - {$past(seenOld[IMM_HI_W-1:0]), $past(seenNew)}) & KEEP_MASK)); // R5
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    spValue[ZERO_LSB-1:0] == '0); // R8
  AST_HOLD_NO_SUB: assert property (@(posedge clk) disable iff (!rstN)
    !spWriteEn |=> $stable(spValue)); // R10
endmodule

bind spSubUnit spSubChecker uChk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .inDelaySlot(inDelaySlot), .rdAddr(rdAddr), .rdData(rdData),
  .spValue(spValue), .spWriteEn(spWriteEn)
);

// File: tb/tb_spSubUnit.sv
module tb_spSubUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        inDelaySlot = 1'b0;
  logic [2:0]  rdAddr;
  logic [23:0] rdData;
  logic [23:0] spValue;
  logic        spWriteEn;

  logic [23:0] regs [8];
  logic [23:0] modelSp;
  logic [12:0] modelOld, modelNew;
  int          modelCount;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;
  assign rdData = regs[rdAddr];

  spSubUnit dut (.*);

  function automatic logic [23:0] clipLow(input logic [23:0] v);
    return {v[23:2], 2'b00};
  endfunction

  function automatic logic [23:0] expectSub(input logic [2:0] rs, input bit ds);
    logic [23:0] r = regs[rs];
    if (ds || modelCount == 0) return clipLow(modelSp - r);
    if (modelCount == 1) return clipLow(r - {11'd0, modelNew});
    return clipLow(r - {modelOld[10:0], modelNew});
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge; check write strobe, then spValue after the edge.
  task automatic step(input bit v, input logic [15:0] w, input bit ds, input string req);
    bit isSub, isPre;
    @(negedge clk);
    instrValid = v; instrWord = w; inDelaySlot = ds;
    isSub = v && (w[15:3] == 13'b0011000000011);
    isPre = v && (w[15:13] == 3'b110);
    #1;
    check("R2 write strobe", {23'd0, spWriteEn}, {23'd0, isSub});
    if (isSub) modelSp = expectSub(w[2:0], ds);
    if (isPre) begin
      modelOld = modelNew; modelNew = w[12:0];
      if (modelCount < 2) modelCount++;
    end else if (v) modelCount = 0;
    @(negedge clk);
    check(req, spValue, modelSp);
    instrValid = 1'b0;
  endtask

  function automatic logic [15:0] subWord(input logic [2:0] rs);
    return {13'b0011000000011, rs};
  endfunction

  function automatic logic [15:0] preWord(input logic [12:0] imm);
    return {3'b110, imm};
  endfunction

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) regs[i] = $urandom;
    regs[2] = 24'h000000;
    modelSp = '0; modelOld = '0; modelNew = '0; modelCount = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1 check("R1 reset sp", spValue, 24'h0);

    // R3: register form, plus wrap below zero
    step(1, subWord(3'd1), 0, "R3 sp minus rs");
    regs[2] = 24'h000010;
    // R4: one prefix
    step(1, preWord(13'h0005), 0, "R10 prefix leaves sp");
    step(1, subWord(3'd2), 0, "R4 rs minus imm13");
    // R5: two prefixes, sample sequence value 0x3ffc
    step(1, preWord(13'h0001), 0, "R10 prefix leaves sp");
    step(1, preWord(13'h1ffc), 0, "R10 prefix leaves sp");
    step(1, subWord(3'd2), 0, "R5 rs minus imm24");
    check("R5 literal", spValue, clipLow(24'h000010 - 24'h003ffc));
    // R9: state cleared after sub -> register form
    step(1, subWord(3'd3), 0, "R9 cleared after sub");
    // R6: three prefixes
    step(1, preWord(13'h1fff), 0, "R6 p1");
    step(1, preWord(13'h0abc), 0, "R6 p2");
    step(1, preWord(13'h1234), 0, "R6 p3");
    step(1, subWord(3'd4), 0, "R6 last two prefixes");
    // R7: delay slot ignores prefixes
    step(1, preWord(13'h0777), 0, "R7 p");
    step(1, subWord(3'd5), 1, "R7 delay slot register form");
    // R9: foreign opcode clears prefix
    step(1, preWord(13'h0100), 0, "R9 p");
    step(1, 16'h1234, 0, "R10 foreign opcode");
    step(1, subWord(3'd6), 0, "R9 cleared by foreign opcode");
    // R10: invalid cycle keeps prefix
    step(1, preWord(13'h0040), 0, "R10 p");
    step(0, subWord(3'd0), 0, "R10 invalid ignored");
    step(1, subWord(3'd7), 0, "R10 prefix kept over idle");

    for (int n = 0; n < 600; n++) begin
      int kind = $urandom_range(0, 9);
      if (($urandom_range(0, 15)) == 0) regs[$urandom_range(0, 7)] = $urandom;
      if (kind < 4) step(1, preWord(13'($urandom)), 0, "R6 random prefix");
      else if (kind < 7) step(1, subWord(3'($urandom)), ($urandom_range(0, 4) == 0), "R5 random sub");
      else if (kind < 9) begin
        logic [15:0] w = 16'($urandom);
        if (w[15:13] == 3'b110 || w[15:3] == 13'b0011000000011) w[15] = ~w[15];
        step(1, w, 0, "R10 random foreign");
      end else step(0, 16'($urandom), 0, "R10 random idle");
      check("R8 low bits", {22'd0, spValue[1:0]}, 24'd0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule